// File: doc/BRIEF.md
# Program Sequencer with Hidden Return Stack

This block sequences instruction fetch for a small 8-bit core with separate program and data memories. It keeps a 13-bit program counter and drives it out as the fetch address. Each cycle the core's decoder raises at most one sequencing command: step to the next address, branch, call, return or interrupt acknowledge. It may also store a data-bus byte into the low half of the counter. When the decoder raises more than one command, a fixed priority picks the one that takes effect.

The upper five counter bits cannot be reached from software. They are taken from a five-bit page register that software loads over the data bus. A branch or call fills the low eleven bits from an instruction literal and the top two bits from the page register. A low-byte write fills the low eight bits from the data bus and all five upper bits from the page register, so software can make computed jumps anywhere in the 8K space.

Return addresses are kept in an eight-entry circular stack that software cannot see. The stack has no pointer that can be read, and it raises no overflow or underflow flag.

Top module: `prog_sequencer`

## Requirements
- R1: When reset is released, the fetch address is 0x000, the page register is 0, and all eight stack entries hold 0x000.
- R2: A step command alone sets the fetch address to its old value plus one, modulo 8192. From 0x1FFF it goes to 0x000.
- R3: A branch sets the fetch address to {page[4:3], lit[10:0]}, where page[4:3] sits in address bits 12:11.
- R4: A call sets the fetch address to the same target as a branch and pushes the old address plus one.
- R5: A return sets the fetch address to the most recently pushed entry that has not yet been popped.
- R6: An interrupt acknowledge pushes the old address plus one and sets the fetch address to 0x004.
- R7: A low-byte write sets the fetch address to {page[4:0], wr_data[7:0]}. The output pc_lo always equals fetch address bits 7:0.
- R8: A page write loads page from wr_data[4:0] and does not change the fetch address. A low-byte write in the same cycle uses the old page value.
- R9: The stack holds eight entries and wraps. A ninth push overwrites the oldest entry. A pop from the emptied stack goes on round the ring and returns the entry in the next slot down.
- R10: Priority runs from interrupt acknowledge, then return, then call, then branch, then low-byte write, then step. Every lower-priority command raised in the same cycle is ignored.
- R11: In a cycle with no sequencing command, the fetch address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advance to the next address |
| goto_en | input | 1 | Branch to the literal target |
| call_en | input | 1 | Call the literal target, pushing the return address |
| ret_en | input | 1 | Return: pop the stack into the counter |
| irq_ack | input | 1 | Interrupt acknowledge: push and go to vector 0x004 |
| lo_wr_en | input | 1 | Data-bus write to the low counter byte |
| page_wr_en | input | 1 | Data-bus write to the page register |
| wr_data | input | 8 | Data-bus write value |
| lit | input | 11 | Literal target from the instruction |
| fetch_addr | output | 13 | Current program counter / fetch address |
| pc_lo | output | 8 | Readable low byte of the counter |

## Verification
Every command takes effect at the first rising edge after it is presented. The new fetch address and pc_lo are therefore valid one cycle after the command. This includes returns, because the stack top is read combinationally. For each command it drives, the driver puts one expected address in a queue. The monitor samples 1 ns after the next rising edge and takes exactly one entry from the queue. Checks therefore stay aligned with that single cycle of latency even when commands come back to back. A return only shows the data a call pushed once the call's cycle has finished. The wrap tests rely on this.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int PC_W     = 13;
  localparam int LIT_W    = 11;
  localparam int DATA_W   = 8;
  localparam int PAGE_W   = PC_W - DATA_W;
  localparam int PAGE_USE = PC_W - LIT_W;
  localparam int STK_DEPTH = 8;
  localparam logic [PC_W-1:0] IRQ_VECTOR = 13'h004;

  typedef logic [PC_W-1:0]   pc_t;
  typedef logic [PAGE_W-1:0] page_t;

  // one-hot selection after priority resolution
  typedef struct packed {
    logic vec;
    logic pop;
    logic call;
    logic jump;
    logic lo;
    logic inc;
  } sel_t;

  function automatic pc_t pc_inc(input pc_t pc);
    return pc + pc_t'(1);
  endfunction

  function automatic pc_t pc_branch(input page_t page, input logic [LIT_W-1:0] l);
    return {page[PAGE_W-1 -: PAGE_USE], l};
  endfunction

  function automatic pc_t pc_lo_load(input page_t page, input logic [DATA_W-1:0] d);
    return {page, d};
  endfunction
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic step_en,
  input  logic goto_en,
  input  logic call_en,
  input  logic ret_en,
  input  logic irq_ack,
  input  logic lo_wr_en,
  output sel_t sel
);
  always_comb begin
    sel      = '0;
    sel.vec  = irq_ack;
    sel.pop  = !irq_ack && ret_en;
    sel.call = !irq_ack && !ret_en && call_en;
    sel.jump = !irq_ack && !ret_en && !call_en && goto_en;
    sel.lo   = !irq_ack && !ret_en && !call_en && !goto_en && lo_wr_en;
    sel.inc  = !irq_ack && !ret_en && !call_en && !goto_en && !lo_wr_en && step_en;
  end

  // R10: resolved selection never carries two commands
  always_comb begin
    assert_sel_onehot_R10: assert ($onehot0(sel));
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack
  import pcseq_pkg::*;
#(
  parameter int DEPTH = STK_DEPTH,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  pc_t  push_val,
  output pc_t  top_val
);
  pc_t              ring [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] top_ptr;

  assign top_ptr = wr_ptr - PTR_W'(1);
  assign top_val = ring[top_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else if (push) begin
      ring[wr_ptr] <= push_val;
      wr_ptr       <= wr_ptr + PTR_W'(1);
    end else if (pop) begin
      wr_ptr <= top_ptr;
    end
  end

  // R9: pointer walks the ring by one per push or pop, wrapping freely
  assert_push_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> wr_ptr == PTR_W'($past(wr_ptr) + 1'b1));
  assert_pop_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> wr_ptr == PTR_W'($past(wr_ptr) - 1'b1));
  // R4: the value just pushed is the one a return would take
  assert_push_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_val == $past(push_val));
  assert_no_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import pcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              goto_en,
  input  logic              call_en,
  input  logic              ret_en,
  input  logic              irq_ack,
  input  logic              lo_wr_en,
  input  logic              page_wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LIT_W-1:0]  lit,
  output logic [PC_W-1:0]   fetch_addr,
  output logic [DATA_W-1:0] pc_lo
);
  pc_t   pc_q, pc_d;
  page_t page_q;
  sel_t  sel;
  pc_t   stk_top;
  pc_t   next_seq;
  pc_t   branch_tgt;
  pc_t   lo_tgt;
  logic  stk_push;
  logic  stk_pop;
  logic  any_cmd;

  pcseq_ctrl u_ctrl (
    .step_en  (step_en),
    .goto_en  (goto_en),
    .call_en  (call_en),
    .ret_en   (ret_en),
    .irq_ack  (irq_ack),
    .lo_wr_en (lo_wr_en),
    .sel      (sel)
  );

  assign next_seq   = pc_inc(pc_q);
  assign branch_tgt = pc_branch(page_q, lit);
  assign lo_tgt     = pc_lo_load(page_q, wr_data);
  assign stk_push   = sel.vec | sel.call;
  assign stk_pop    = sel.pop;
  assign any_cmd    = |sel;

  pcseq_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (stk_push),
    .pop      (stk_pop),
    .push_val (next_seq),
    .top_val  (stk_top)
  );

  always_comb begin
    unique case (1'b1)
      sel.vec:  pc_d = IRQ_VECTOR;
      sel.pop:  pc_d = stk_top;
      sel.call: pc_d = branch_tgt;
      sel.jump: pc_d = branch_tgt;
      sel.lo:   pc_d = lo_tgt;
      sel.inc:  pc_d = next_seq;
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      page_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (page_wr_en) page_q <= wr_data[PAGE_W-1:0];
    end
  end

  assign fetch_addr = pc_q;
  assign pc_lo      = pc_q[DATA_W-1:0];

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel.inc |=> fetch_addr == pc_t'($past(fetch_addr) + 1'b1));
  assert_branch_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.jump || sel.call) |=> fetch_addr[LIT_W-1:0] == $past(lit));
  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> fetch_addr == IRQ_VECTOR);
  assert_lo_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel.lo |=> pc_lo == $past(wr_data));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> $stable(fetch_addr));
endmodule

// File: tb/prog_sequencer_tb.sv
`timescale 1ns/1ps
module prog_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 0, goto_en = 0, call_en = 0, ret_en = 0, irq_ack = 0;
  logic lo_wr_en = 0, page_wr_en = 0;
  logic [7:0]  wr_data = '0;
  logic [10:0] lit = '0;
  logic [12:0] fetch_addr;
  logic [7:0]  pc_lo;

  always #2.5 clk = ~clk;

  prog_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .goto_en(goto_en),
    .call_en(call_en), .ret_en(ret_en), .irq_ack(irq_ack),
    .lo_wr_en(lo_wr_en), .page_wr_en(page_wr_en), .wr_data(wr_data),
    .lit(lit), .fetch_addr(fetch_addr), .pc_lo(pc_lo)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { logic [12:0] pc; string tag; } exp_t;
  exp_t sb[$];

  // reference state, built from the requirements
  logic [12:0] m_pc = '0;
  logic [4:0]  m_page = '0;
  logic [12:0] m_ring [8];
  int          m_cnt = 0;

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%03h expected=0x%03h", tag, act, exp);
    end
  endtask

  function automatic void m_push(input logic [12:0] v);
    m_ring[m_cnt % 8] = v;
    m_cnt = (m_cnt + 1) % 8;
  endfunction

  function automatic logic [12:0] m_pop();
    m_cnt = (m_cnt + 7) % 8;
    return m_ring[m_cnt];
  endfunction

  task automatic drive(input bit s, g, c, r, i, lw, pw,
                       input logic [7:0] d, input logic [10:0] l, input string tag);
    logic [12:0] nxt;
    logic [12:0] inc;
    @(negedge clk);
    step_en = s; goto_en = g; call_en = c; ret_en = r; irq_ack = i;
    lo_wr_en = lw; page_wr_en = pw; wr_data = d; lit = l;
    inc = m_pc + 13'd1;
    nxt = m_pc;
    if (i)       begin m_push(inc); nxt = 13'h004; end
    else if (r)  nxt = m_pop();
    else if (c)  begin m_push(inc); nxt = {m_page[4:3], l}; end
    else if (g)  nxt = {m_page[4:3], l};
    else if (lw) nxt = {m_page, d};
    else if (s)  nxt = inc;
    if (pw) m_page = d[4:0];
    m_pc = nxt;
    sb.push_back('{nxt, tag});
  endtask

  task automatic idle_cmd(input string tag);
    drive(0,0,0,0,0,0,0, 8'h00, 11'h000, tag);
  endtask

  // monitor: one expected address per cycle, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " addr"}, fetch_addr, e.pc);
        check({e.tag, " pc_lo"}, {5'd0, pc_lo}, {5'd0, e.pc[7:0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m_ring[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset addr", fetch_addr, 13'h000);
    check("R1 reset pc_lo", {5'd0, pc_lo}, 13'h000);

    drive(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2 step1");
    drive(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2 step2");
    drive(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2 step3");
    drive(0,0,0,0,0,0,1, 8'h1F, 11'h000, "R8 page write no effect");
    idle_cmd("R11 idle hold");
    drive(0,0,0,0,0,1,0, 8'hFF, 11'h000, "R7 computed jump to 0x1FFF");
    drive(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2 wrap to 0x000");
    drive(0,1,0,0,0,0,0, 8'h00, 11'h123, "R3 branch page bits 11");
    drive(0,0,0,0,0,0,1, 8'h08, 11'h000, "R8 page write 0x08");
    drive(0,0,1,0,0,0,0, 8'h00, 11'h050, "R4 call outer");
    drive(0,0,1,0,0,0,0, 8'h00, 11'h7FF, "R4 call inner");
    drive(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2 step in callee");
    drive(0,0,0,1,0,0,0, 8'h00, 11'h000, "R5 return inner");
    drive(0,0,0,1,0,0,0, 8'h00, 11'h000, "R5 return outer");
    drive(0,0,0,0,1,0,0, 8'h00, 11'h000, "R6 irq vector");
    drive(1,0,0,0,0,0,0, 8'h00, 11'h000, "R2 step in handler");
    drive(0,0,0,1,0,0,0, 8'h00, 11'h000, "R6 return from irq");
    drive(0,0,0,1,1,0,0, 8'h00, 11'h000, "R10 irq over return");
    drive(0,0,0,1,0,0,0, 8'h00, 11'h000, "R10 return after irq");
    drive(0,0,1,1,0,0,0, 8'h00, 11'h3AA, "R10 return over call");
    drive(0,1,1,0,0,0,0, 8'h00, 11'h010, "R10 call over branch");
    drive(0,1,0,0,0,1,0, 8'h33, 11'h020, "R10 branch over lo write");
    drive(1,0,0,0,0,1,0, 8'h44, 11'h000, "R10 lo write over step");
    drive(0,0,0,0,0,1,1, 8'h15, 11'h000, "R8 lo write uses old page");
    drive(0,1,0,0,0,0,0, 8'h00, 11'h001, "R8 new page bits 10");
    for (int k = 1; k <= 9; k++)
      drive(0,0,1,0,0,0,0, 8'h00, 11'(k * 16), "R9 call chain");
    for (int k = 0; k < 10; k++)
      drive(0,0,0,1,0,0,0, 8'h00, 11'h000, "R9 unwind with wrap");
    idle_cmd("R11 final idle");
    @(posedge clk);
    #2;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule